// File: doc/BRIEF.md
# Tunnel Endpoint Protocol Adaptation Layer

This block sits at the device end of a packet tunnel. On one side is the stage that splits and rebuilds frames. On the other side is the link layer of the native protocol. Packets arrive as a byte stream, and each one carries a 4-bit type code on its first byte. The block uses that code to sort each packet. Data packets pass through to the link layer untouched. Management packets are consumed inside the block and never reach the link layer.

The block holds a small management register file of 32 words, each 16 bits wide. One address of that file mirrors a live link-status input. A management write updates the file and sends nothing back. A management read produces a fixed four-byte reply, typed as a management read, which goes back toward the splitting stage. While a reply is waiting to be taken, further read requests are stalled at their first byte, but data packets keep flowing. Malformed packets, unknown types and oversize data packets are counted in a saturating error counter.

Every stream uses a valid/ready handshake. The data path and the neighbour interfaces stay the same whatever native protocol is carried. Only the handling of management packets is specific to the protocol.

Top module: `tunnel_adapt_layer`

## Requirements
- R1: A packet whose type code (sampled on its first byte) is 0 goes out on the data port byte for byte. Its end marker appears only on its final byte. Backpressure from the data port stalls the input.
- R2: A packet of type 1 (management read) produces one reply of exactly 4 bytes. The reply bytes are the PHY address (payload byte 0, low 5 bits), then the register address (payload byte 1, low 5 bits), then read data bits 15:8, then bits 7:0. The end marker is on byte 4 and the reply type code is 1.
- R3: Packets of any type other than 0 never produce a beat on the data port.
- R4: A packet of type 2 (management write) writes {payload byte 2, payload byte 3} into the register addressed by payload byte 1. It produces no reply.
- R5: Register address 1 always reads the live link-status input. Writes to address 1 have no effect.
- R6: While a reply byte is offered and not taken, the reply valid, data and end marker stay unchanged.
- R7: A type 0 packet longer than 256 bytes has its 256th byte marked as last. Its remaining bytes are discarded, and the error counter rises by one.
- R8: While a reply is pending, a type 1 packet is not accepted at its first byte. Type 0 packets are still accepted.
- R9: The error counter rises by one for each packet of type 3 to 15, for each type 1 packet shorter than 2 bytes and for each type 2 packet shorter than 4 bytes. Short packets cause no register write and no reply. The counter saturates at its all-ones value.
- R10: After reset no output is valid, the error counter is 0 and every stored register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Tunnel byte offered |
| in_ready | output | 1 | Tunnel byte accepted |
| in_type | input | 4 | Packet type code, sampled on the first byte |
| in_data | input | 8 | Tunnel payload byte |
| in_last | input | 1 | Final byte of the tunnel packet |
| dout_valid | output | 1 | Data byte toward the link layer |
| dout_ready | input | 1 | Link layer accepts the byte |
| dout_data | output | 8 | Forwarded byte |
| dout_last | output | 1 | Final forwarded byte of the packet |
| rep_valid | output | 1 | Reply byte offered to the splitting stage |
| rep_ready | input | 1 | Splitting stage takes the reply byte |
| rep_type | output | 4 | Reply packet type code (1) |
| rep_data | output | 8 | Reply byte |
| rep_last | output | 1 | Final reply byte |
| link_status_i | input | 16 | Live link-status word |
| err_count | output | ERR_W | Saturating error counter |

## Verification
Data packets are tried with a free-running data port and with a port that alternates ready. This tells a pure pass-through apart from one that drops or repeats bytes under stall. Read-after-write to a stored address and read of the live address separate the register file from the live mirror. A write to the live address shows whether that write is really ignored. Runs of 1, 2, 3 and 4 bytes for each type exercise the short-packet checks. A 300-byte data packet sits on the length limit and shows the difference between truncation and plain forwarding. Holding the reply stalled while a data packet and a read packet arrive shows which kind of traffic is held off.

// File: rtl/tal_pkg.sv
package tal_pkg;

   localparam int unsigned FIELD_W    = 5;
   localparam int unsigned REG_W      = 16;
   localparam int unsigned REG_DEPTH  = 1 << FIELD_W;
   localparam int unsigned REPLY_LEN  = 4;

   localparam logic [3:0] TYPE_DATA = 4'd0;
   localparam logic [3:0] TYPE_MRD  = 4'd1;
   localparam logic [3:0] TYPE_MWR  = 4'd2;

   typedef enum logic [2:0] {
      CL_DATA,
      CL_MRD,
      CL_MWR,
      CL_DROP,
      CL_TRUNC
   } pkt_class_e;

   function automatic pkt_class_e class_of(input logic [3:0] code);
      pkt_class_e c;
      case (code)
         TYPE_DATA: c = CL_DATA;
         TYPE_MRD:  c = CL_MRD;
         TYPE_MWR:  c = CL_MWR;
         default:   c = CL_DROP;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/tal_rx_router.sv
module tal_rx_router
   import tal_pkg::*;
#(
   parameter int unsigned MAX_PAYLOAD = 256
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic [3:0]         in_type,
   input  logic [7:0]         in_data,
   input  logic               in_last,
   input  logic               reply_busy,
   output logic               dout_valid,
   input  logic               dout_ready,
   output logic [7:0]         dout_data,
   output logic               dout_last,
   output logic               rd_en,
   output logic               wr_en,
   output logic [FIELD_W-1:0] acc_phy,
   output logic [FIELD_W-1:0] acc_addr,
   output logic [REG_W-1:0]   wr_data,
   output logic               err_evt
);

   localparam int unsigned CNT_W = $clog2(MAX_PAYLOAD + 1);
   localparam logic [CNT_W-1:0] LIMIT_IDX = CNT_W'(MAX_PAYLOAD - 1);
   localparam logic [CNT_W-1:0] CNT_MAX   = CNT_W'(MAX_PAYLOAD);

   logic               in_pkt_q;
   pkt_class_e         cls_q;
   pkt_class_e         cur_cls;
   logic [CNT_W-1:0]   cnt_q;
   logic [CNT_W-1:0]   beat_idx;
   logic [FIELD_W-1:0] phy_q;
   logic [FIELD_W-1:0] reg_q;
   logic [7:0]         hi_q;
   logic [7:0]         lo_q;
   logic               at_limit;
   logic               fire;
   logic               pkt_end;
   logic               is_mgmt;

   assign beat_idx = in_pkt_q ? cnt_q : '0;
   assign cur_cls  = in_pkt_q ? cls_q : class_of(in_type);
   assign at_limit = (beat_idx == LIMIT_IDX);
   assign is_mgmt  = (cur_cls == CL_MRD) || (cur_cls == CL_MWR);

   always_comb begin
      case (cur_cls)
         CL_DATA: in_ready = dout_ready;
         CL_MRD:  in_ready = in_pkt_q | ~reply_busy;
         default: in_ready = 1'b1;
      endcase
   end

   assign dout_valid = in_valid && (cur_cls == CL_DATA);
   assign dout_data  = in_data;
   assign dout_last  = in_last | at_limit;

   assign fire    = in_valid & in_ready;
   assign pkt_end = fire & in_last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_pkt_q <= 1'b0;
         cls_q    <= CL_DATA;
         cnt_q    <= '0;
      end else if (fire) begin
         in_pkt_q <= ~in_last;
         if (cur_cls == CL_DATA && at_limit)
            cls_q <= CL_TRUNC;
         else
            cls_q <= cur_cls;
         cnt_q <= (beat_idx == CNT_MAX) ? beat_idx : beat_idx + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phy_q <= '0;
         reg_q <= '0;
         hi_q  <= '0;
         lo_q  <= '0;
      end else if (fire && is_mgmt) begin
         case (beat_idx)
            CNT_W'(0): phy_q <= in_data[FIELD_W-1:0];
            CNT_W'(1): reg_q <= in_data[FIELD_W-1:0];
            CNT_W'(2): hi_q  <= in_data;
            CNT_W'(3): lo_q  <= in_data;
            default: ;
         endcase
      end
   end

   assign acc_phy  = phy_q;
   assign acc_addr = (beat_idx == CNT_W'(1)) ? in_data[FIELD_W-1:0] : reg_q;
   assign wr_data  = {hi_q, (beat_idx == CNT_W'(3)) ? in_data : lo_q};

   assign rd_en = pkt_end && (cur_cls == CL_MRD) && (beat_idx >= CNT_W'(1));
   assign wr_en = pkt_end && (cur_cls == CL_MWR) && (beat_idx >= CNT_W'(3));

   assign err_evt = (fire && !in_pkt_q && cur_cls == CL_DROP)
                 || (pkt_end && cur_cls == CL_MRD && beat_idx < CNT_W'(1))
                 || (pkt_end && cur_cls == CL_MWR && beat_idx < CNT_W'(3))
                 || (fire && cur_cls == CL_DATA && at_limit && !in_last);

   AST_CTL_NOT_FORWARDED: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_pkt_q && in_type != TYPE_DATA) |-> !dout_valid); // R3

   AST_READ_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (reply_busy && in_valid && !in_pkt_q && in_type == TYPE_MRD) |-> !in_ready); // R8

   AST_DATA_NOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (reply_busy && in_valid && !in_pkt_q && in_type == TYPE_DATA && dout_ready) |-> in_ready); // R8

endmodule

// File: rtl/tal_mgmt_regs.sv
module tal_mgmt_regs
   import tal_pkg::*;
#(
   parameter bit          LIVE_EN   = 1'b1,
   parameter int unsigned LIVE_ADDR = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [FIELD_W-1:0] addr,
   input  logic [REG_W-1:0]   wr_data,
   input  logic [REG_W-1:0]   link_status_i,
   output logic [REG_W-1:0]   rd_data
);

   localparam logic [FIELD_W-1:0] LIVE_A = FIELD_W'(LIVE_ADDR);

   logic [REG_W-1:0] mem [REG_DEPTH];
   logic             hits_live;

   generate
      if (LIVE_EN) begin : g_live
         assign hits_live = (addr == LIVE_A);
         assign rd_data   = hits_live ? link_status_i : mem[addr];
      end else begin : g_plain
         assign hits_live = 1'b0;
         assign rd_data   = mem[addr];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(REG_DEPTH); i++)
            mem[i] <= '0;
      end else if (wr_en && !hits_live) begin
         mem[addr] <= wr_data;
      end
   end

endmodule

// File: rtl/tal_reply_gen.sv
module tal_reply_gen
   import tal_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [FIELD_W-1:0] phy,
   input  logic [FIELD_W-1:0] addr,
   input  logic [REG_W-1:0]   data,
   output logic               busy,
   output logic               rep_valid,
   input  logic               rep_ready,
   output logic [3:0]         rep_type,
   output logic [7:0]         rep_data,
   output logic               rep_last
);

   localparam int unsigned IDX_W = $clog2(REPLY_LEN);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(REPLY_LEN - 1);

   logic [FIELD_W-1:0] phy_q;
   logic [FIELD_W-1:0] addr_q;
   logic [REG_W-1:0]   data_q;
   logic [IDX_W-1:0]   idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         idx_q  <= '0;
         phy_q  <= '0;
         addr_q <= '0;
         data_q <= '0;
      end else if (start) begin
         busy   <= 1'b1;
         idx_q  <= '0;
         phy_q  <= phy;
         addr_q <= addr;
         data_q <= data;
      end else if (busy && rep_ready) begin
         idx_q <= idx_q + 1'b1;
         if (idx_q == LAST_IDX)
            busy <= 1'b0;
      end
   end

   always_comb begin
      case (idx_q)
         IDX_W'(0): rep_data = {{(8 - FIELD_W){1'b0}}, phy_q};
         IDX_W'(1): rep_data = {{(8 - FIELD_W){1'b0}}, addr_q};
         IDX_W'(2): rep_data = data_q[15:8];
         default:   rep_data = data_q[7:0];
      endcase
   end

   assign rep_valid = busy;
   assign rep_last  = busy && (idx_q == LAST_IDX);
   assign rep_type  = TYPE_MRD;

   AST_REPLY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rep_valid && !rep_ready) |=> (rep_valid && $stable(rep_data) && $stable(rep_last))); // R6

   AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy); // R8

endmodule

// File: rtl/tal_err_count.sv
module tal_err_count #(
   parameter int unsigned ERR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   output logic [ERR_W-1:0] count
);

   always_ff @(posedge clk) begin
      if (!rst_n)
         count <= '0;
      else if (inc && !(&count))
         count <= count + 1'b1;
   end

   AST_ERR_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
      count >= $past(count)); // R9

   AST_ERR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !(&count)) |=> (count != $past(count))); // R9

endmodule

// File: rtl/tunnel_adapt_layer.sv
module tunnel_adapt_layer
   import tal_pkg::*;
#(
   parameter int unsigned MAX_PAYLOAD = 256,
   parameter int unsigned ERR_W       = 8,
   parameter bit          LIVE_EN     = 1'b1,
   parameter int unsigned LIVE_ADDR   = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [3:0]       in_type,
   input  logic [7:0]       in_data,
   input  logic             in_last,
   output logic             dout_valid,
   input  logic             dout_ready,
   output logic [7:0]       dout_data,
   output logic             dout_last,
   output logic             rep_valid,
   input  logic             rep_ready,
   output logic [3:0]       rep_type,
   output logic [7:0]       rep_data,
   output logic             rep_last,
   input  logic [15:0]      link_status_i,
   output logic [ERR_W-1:0] err_count
);

   localparam int unsigned OB_W = $clog2(MAX_PAYLOAD + 1);

   initial begin
      if (MAX_PAYLOAD < REPLY_LEN || MAX_PAYLOAD > 256)
         $error("MAX_PAYLOAD must lie between 4 and 256");
      if (ERR_W < 1)
         $error("ERR_W must be at least 1");
      if (LIVE_ADDR >= REG_DEPTH)
         $error("LIVE_ADDR outside the register file");
   end

   logic               reply_busy;
   logic               rd_en;
   logic               wr_en;
   logic [FIELD_W-1:0] acc_phy;
   logic [FIELD_W-1:0] acc_addr;
   logic [REG_W-1:0]   wr_data;
   logic [REG_W-1:0]   rd_data;
   logic               err_evt;

   tal_rx_router #(.MAX_PAYLOAD(MAX_PAYLOAD)) u_router (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_ready   (in_ready),
      .in_type    (in_type),
      .in_data    (in_data),
      .in_last    (in_last),
      .reply_busy (reply_busy),
      .dout_valid (dout_valid),
      .dout_ready (dout_ready),
      .dout_data  (dout_data),
      .dout_last  (dout_last),
      .rd_en      (rd_en),
      .wr_en      (wr_en),
      .acc_phy    (acc_phy),
      .acc_addr   (acc_addr),
      .wr_data    (wr_data),
      .err_evt    (err_evt)
   );

   tal_mgmt_regs #(.LIVE_EN(LIVE_EN), .LIVE_ADDR(LIVE_ADDR)) u_regs (
      .clk           (clk),
      .rst_n         (rst_n),
      .wr_en         (wr_en),
      .addr          (acc_addr),
      .wr_data       (wr_data),
      .link_status_i (link_status_i),
      .rd_data       (rd_data)
   );

   tal_reply_gen u_reply (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (rd_en),
      .phy       (acc_phy),
      .addr      (acc_addr),
      .data      (rd_data),
      .busy      (reply_busy),
      .rep_valid (rep_valid),
      .rep_ready (rep_ready),
      .rep_type  (rep_type),
      .rep_data  (rep_data),
      .rep_last  (rep_last)
   );

   tal_err_count #(.ERR_W(ERR_W)) u_err (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (err_evt),
      .count (err_count)
   );

   // Independent count of forwarded beats in the current output packet
   logic [OB_W-1:0] out_beats;

   always_ff @(posedge clk) begin
      if (!rst_n)
         out_beats <= '0;
      else if (dout_valid && dout_ready)
         out_beats <= dout_last ? '0 : out_beats + 1'b1;
   end

   AST_NO_OVERSIZE: assert property (@(posedge clk) disable iff (!rst_n)
      dout_valid |-> (out_beats < OB_W'(MAX_PAYLOAD))); // R7

   AST_MGMT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en || wr_en) |-> !dout_valid); // R3

endmodule

// File: tb/tb_tunnel_adapt_layer.sv
`timescale 1ns/1ps
module tb_tunnel_adapt_layer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [3:0]  in_type = 4'd0;
   logic [7:0]  in_data = 8'd0;
   logic        in_last = 1'b0;
   logic        dout_valid;
   logic        dout_ready = 1'b1;
   logic [7:0]  dout_data;
   logic        dout_last;
   logic        rep_valid;
   logic        rep_ready = 1'b1;
   logic [3:0]  rep_type;
   logic [7:0]  rep_data;
   logic        rep_last;
   logic [15:0] link_status_i = 16'h0000;
   logic [7:0]  err_count;

   always #5 clk = ~clk;

   tunnel_adapt_layer dut (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_type(in_type),
      .in_data(in_data), .in_last(in_last),
      .dout_valid(dout_valid), .dout_ready(dout_ready),
      .dout_data(dout_data), .dout_last(dout_last),
      .rep_valid(rep_valid), .rep_ready(rep_ready), .rep_type(rep_type),
      .rep_data(rep_data), .rep_last(rep_last),
      .link_status_i(link_status_i), .err_count(err_count)
   );

   int n_chk = 0;
   int n_fail = 0;
   int exp_err = 0;
   bit stall_mode = 1'b0;

   logic [7:0] pbuf [0:319];
   logic [7:0] dbuf [0:1023];
   logic       dlst [0:1023];
   int         dcnt = 0;
   logic [7:0] rbuf [0:63];
   logic       rlst [0:63];
   logic [3:0] rtyp [0:63];
   int         rcnt = 0;
   int         stab_viol = 0;
   logic       prev_stall = 1'b0;
   logic [7:0] prev_rd = 8'd0;
   logic       prev_rl = 1'b0;

   always @(posedge clk) begin
      if (dout_valid && dout_ready && dcnt < 1024) begin
         dbuf[dcnt] = dout_data;
         dlst[dcnt] = dout_last;
         dcnt++;
      end
      if (prev_stall && (!rep_valid || rep_data != prev_rd || rep_last != prev_rl))
         stab_viol++;
      prev_stall = rep_valid && !rep_ready;
      prev_rd    = rep_data;
      prev_rl    = rep_last;
      if (rep_valid && rep_ready && rcnt < 64) begin
         rbuf[rcnt] = rep_data;
         rlst[rcnt] = rep_last;
         rtyp[rcnt] = rep_type;
         rcnt++;
      end
   end

   always @(posedge clk) begin
      #2;
      dout_ready = stall_mode ? ~dout_ready : 1'b1;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send_pkt(input logic [3:0] typ, input int len);
      for (int i = 0; i < len; i++) begin
         bit ok;
         in_valid = 1'b1;
         in_type  = typ;
         in_data  = pbuf[i];
         in_last  = (i == len - 1);
         ok = 1'b0;
         while (!ok) begin
            @(negedge clk);
            ok = in_ready;
            @(posedge clk);
         end
         #1;
      end
      in_valid = 1'b0;
      in_last  = 1'b0;
   endtask

   task automatic wait_cycles(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic mdio_write(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] v);
      pbuf[0] = {3'b0, phy};
      pbuf[1] = {3'b0, ra};
      pbuf[2] = v[15:8];
      pbuf[3] = v[7:0];
      send_pkt(4'd2, 4);
   endtask

   task automatic mdio_read(input logic [4:0] phy, input logic [4:0] ra);
      pbuf[0] = {3'b0, phy};
      pbuf[1] = {3'b0, ra};
      send_pkt(4'd1, 2);
   endtask

   task automatic wait_reply(input int target);
      int guard;
      guard = 0;
      while (rcnt < target && guard < 200) begin
         @(posedge clk);
         guard++;
      end
      #1;
   endtask

   task automatic check_reply(input int base, input logic [4:0] phy, input logic [4:0] ra,
                              input logic [15:0] v, input string req);
      logic [7:0] e [4];
      e[0] = {3'b0, phy};
      e[1] = {3'b0, ra};
      e[2] = v[15:8];
      e[3] = v[7:0];
      chk(rcnt >= base + 4, req, rcnt, base + 4);
      for (int k = 0; k < 4; k++) begin
         chk(rbuf[base + k] == e[k], req, rbuf[base + k], e[k]);
         chk(rlst[base + k] == (k == 3), req, rlst[base + k], (k == 3));
         chk(rtyp[base + k] == 4'd1, req, rtyp[base + k], 1);
      end
   endtask

   task automatic t_reset;
      chk(dout_valid == 1'b0, "R10 dout_valid after reset", dout_valid, 0);
      chk(rep_valid == 1'b0, "R10 rep_valid after reset", rep_valid, 0);
      chk(err_count == 8'd0, "R10 err_count after reset", err_count, 0);
      mdio_read(5'd2, 5'd9);
      wait_reply(4);
      check_reply(0, 5'd2, 5'd9, 16'h0000, "R10 stored register after reset");
   endtask

   task automatic t_data(input int len, input bit stall);
      int base;
      int lasts;
      base = dcnt;
      stall_mode = stall;
      for (int i = 0; i < len; i++) pbuf[i] = 8'(i * 7 + 3);
      send_pkt(4'd0, len);
      stall_mode = 1'b0;
      wait_cycles(2);
      chk(dcnt == base + len, "R1 forwarded byte count", dcnt - base, len);
      lasts = 0;
      for (int i = 0; i < len; i++) begin
         if (dbuf[base + i] != 8'(i * 7 + 3))
            chk(1'b0, "R1 forwarded byte", dbuf[base + i], 8'(i * 7 + 3));
         if (dlst[base + i]) lasts++;
      end
      chk(dlst[base + len - 1] == 1'b1 && lasts == 1, "R1 end marker only on final byte", lasts, 1);
      chk(err_count == 8'(exp_err), "R1 no error for data", err_count, exp_err);
   endtask

   task automatic t_write_read;
      int d0;
      int r0;
      d0 = dcnt;
      r0 = rcnt;
      mdio_write(5'd3, 5'd5, 16'hBEEF);
      wait_cycles(6);
      chk(rcnt == r0, "R4 write gives no reply", rcnt - r0, 0);
      chk(dcnt == d0, "R3 write not forwarded", dcnt - d0, 0);
      mdio_read(5'd3, 5'd5);
      wait_reply(r0 + 4);
      check_reply(r0, 5'd3, 5'd5, 16'hBEEF, "R2 read-back of written register");
      chk(dcnt == d0, "R3 read not forwarded", dcnt - d0, 0);
   endtask

   task automatic t_live;
      int r0;
      r0 = rcnt;
      link_status_i = 16'h1234;
      mdio_read(5'd0, 5'd1);
      wait_reply(r0 + 4);
      check_reply(r0, 5'd0, 5'd1, 16'h1234, "R5 live status read");
      mdio_write(5'd0, 5'd1, 16'hFFFF);
      link_status_i = 16'h0042;
      mdio_read(5'd0, 5'd1);
      wait_reply(r0 + 8);
      check_reply(r0 + 4, 5'd0, 5'd1, 16'h0042, "R5 write to live address ignored");
   endtask

   task automatic t_holdoff;
      int r0;
      int d0;
      bit seen_ready;
      r0 = rcnt;
      rep_ready = 1'b0;
      stab_viol = 0;
      mdio_write(5'd4, 5'd7, 16'hA55A);
      mdio_read(5'd4, 5'd7);
      wait_cycles(3);
      chk(rep_valid == 1'b1, "R6 reply offered while stalled", rep_valid, 1);
      d0 = dcnt;
      pbuf[0] = 8'h11; pbuf[1] = 8'h22; pbuf[2] = 8'h33;
      send_pkt(4'd0, 3);
      wait_cycles(2);
      chk(dcnt == d0 + 3, "R8 data flows while reply pending", dcnt - d0, 3);
      in_valid = 1'b1;
      in_type  = 4'd1;
      in_data  = 8'd4;
      in_last  = 1'b0;
      seen_ready = 1'b0;
      repeat (6) begin
         @(negedge clk);
         if (in_ready) seen_ready = 1'b1;
      end
      chk(!seen_ready, "R8 read held off while reply pending", seen_ready, 0);
      chk(rcnt == r0, "R6 no reply byte taken while stalled", rcnt - r0, 0);
      @(posedge clk);
      #1;
      rep_ready = 1'b1;
      mdio_read(5'd4, 5'd7);
      wait_reply(r0 + 8);
      check_reply(r0, 5'd4, 5'd7, 16'hA55A, "R2 first reply after stall");
      check_reply(r0 + 4, 5'd4, 5'd7, 16'hA55A, "R8 held read served afterwards");
      chk(stab_viol == 0, "R6 reply stable while not taken", stab_viol, 0);
   endtask

   task automatic t_trunc;
      int base;
      int lasts;
      base = dcnt;
      stall_mode = 1'b1;
      for (int i = 0; i < 300; i++) pbuf[i] = 8'(i) ^ 8'h5A;
      send_pkt(4'd0, 300);
      stall_mode = 1'b0;
      exp_err++;
      wait_cycles(2);
      chk(dcnt == base + 256, "R7 truncated length", dcnt - base, 256);
      lasts = 0;
      for (int i = 0; i < 256; i++) begin
         if (dbuf[base + i] != (8'(i) ^ 8'h5A))
            chk(1'b0, "R7 truncated content", dbuf[base + i], 8'(i) ^ 8'h5A);
         if (dlst[base + i]) lasts++;
      end
      chk(dlst[base + 255] == 1'b1 && lasts == 1, "R7 end marker on 256th byte", lasts, 1);
      chk(err_count == 8'(exp_err), "R7 oversize counted", err_count, exp_err);
      t_data(2, 1'b0);
   endtask

   task automatic t_errors;
      int d0;
      int r0;
      d0 = dcnt;
      r0 = rcnt;
      pbuf[0] = 8'h01; pbuf[1] = 8'h02; pbuf[2] = 8'h03;
      send_pkt(4'd7, 3);
      exp_err++;
      wait_cycles(2);
      chk(err_count == 8'(exp_err), "R9 unknown type counted", err_count, exp_err);
      chk(dcnt == d0, "R3 unknown type not forwarded", dcnt - d0, 0);
      pbuf[0] = 8'h03;
      send_pkt(4'd1, 1);
      exp_err++;
      wait_cycles(6);
      chk(err_count == 8'(exp_err), "R9 short read counted", err_count, exp_err);
      chk(rcnt == r0, "R9 short read gives no reply", rcnt - r0, 0);
      pbuf[0] = 8'h03; pbuf[1] = 8'h05; pbuf[2] = 8'h77;
      send_pkt(4'd2, 3);
      exp_err++;
      wait_cycles(2);
      chk(err_count == 8'(exp_err), "R9 short write counted", err_count, exp_err);
      mdio_read(5'd3, 5'd5);
      wait_reply(r0 + 4);
      check_reply(r0, 5'd3, 5'd5, 16'hBEEF, "R9 short write left register");
      chk(dcnt == d0, "R3 control packets not forwarded", dcnt - d0, 0);
   endtask

   task automatic t_saturate;
      pbuf[0] = 8'h00;
      for (int i = 0; i < 260; i++) send_pkt(4'd15, 1);
      wait_cycles(2);
      chk(err_count == 8'hFF, "R9 counter saturates", err_count, 255);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      #1;
      rst_n = 1'b1;
      wait_cycles(1);
      t_reset();
      t_data(5, 1'b0);
      t_data(20, 1'b1);
      t_write_read();
      t_live();
      t_holdoff();
      t_trunc();
      t_errors();
      t_saturate();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule